// File: doc/BRIEF.md
# DMA Bridge Interrupt Status Controller

This block sits beside a DMA bridge that moves data between USB buffer memory, two audio units and main memory. The bridge reports ten kinds of event as one-cycle pulses:

- USB transfer complete.
- USB address fault.
- For each of the two audio units, buffer-complete and buffer-midpoint, in both the playback and capture directions.

Each pulse sets a sticky pending flag. Each event also has its own enable flag.

All pending and enable flags live in a single 32-bit register. Software reads it, and writes it back through a plain write strobe with write data. A pending flag is cleared by writing a 0 to its bit. Writing a 1 leaves a pending flag as it is. An enable flag takes the written value.

Three level interrupt outputs each gather a fixed group of enabled pending events:

- Line 0 carries the USB fault.
- Line 1 carries every completion event.
- Line 2 carries the audio midpoint events.

Top module: `brg_irq_ctrl`

## Requirements
- R1: A pulse on `evt_pulse[n]` sets pending flag n at the next clock edge, whether or not enable n is set. An enabled event never drives an interrupt line while its enable is clear.
- R2: Writing 1 to a pending bit leaves it unchanged. A set pending flag stays set until it is acknowledged or reset.
- R3: Writing 0 to a pending bit clears that flag at the write edge. Other pending flags written with 1 are unaffected.
- R4: When an event pulse and a write of 0 to the same pending bit arrive on the same edge, the flag ends up set.
- R5: Every write loads each enable flag from its bit of `reg_wdata`. Enable bits are: event 0 at bit 8, event 1 at bit 9, and event n (2..9) at bit n+22. Clearing an enable leaves the pending flag untouched.
- R6: Pending bits are: event 0 at bit 0, event 1 at bit 1, and event n (2..9) at bit n+14. Event numbering is:
  - 0: USB transfer complete.
  - 1: USB address fault.
  - 2 to 5: unit 0 play complete, play midpoint, capture complete, capture midpoint.
  - 6 to 9: the same four for unit 1.
- R7: `irq_out[0]` is high exactly when event 1 is pending and enabled.
- R8: `irq_out[1]` is high exactly when at least one of events 0, 2, 4, 6, 8 is pending and enabled.
- R9: `irq_out[2]` is high exactly when at least one of events 3, 5, 7, 9 is pending and enabled.
- R10: Each interrupt line is registered. It follows its group's pending-and-enabled state one clock edge after the register changes, both when rising and when falling.
- R11: Synchronous reset clears every pending and enable flag and drives all interrupt lines low.
- R12: Bits 2..7 and 10..15 of the register read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the flag register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| evt_pulse | input | 10 | One-cycle event pulses, bit n is event n |
| irq_out | output | 3 | Level interrupt lines 0..2 |

## Verification
The bench drives an event on the same edge as a zero-write acknowledge of that event. A design that lets the acknowledge win would lose an interrupt.

It writes all ones over pending bits and checks they survive. A design with write-one-to-clear or plain-store pending bits would wipe or invent flags.

It raises each event alone with only its own enable set, so a wrong bit position or a wrong line grouping shows up as the wrong line rising. It also checks the cycle the line moves, which catches an unregistered or doubly-registered output.

Masking an event while it is pending must drop its line and keep the flag. Writing ones over the unused bits must read back as zeros.

// File: rtl/brg_irq_pkg.sv
package brg_irq_pkg;

    localparam int NUM_EVT  = 10;
    localparam int REG_W    = 32;
    localparam int NUM_LINE = 3;

    typedef enum logic [3:0] {
        EV_USB_DONE   = 4'd0,
        EV_USB_FAULT  = 4'd1,
        EV_U0_PLAY_F  = 4'd2,
        EV_U0_PLAY_H  = 4'd3,
        EV_U0_CAP_F   = 4'd4,
        EV_U0_CAP_H   = 4'd5,
        EV_U1_PLAY_F  = 4'd6,
        EV_U1_PLAY_H  = 4'd7,
        EV_U1_CAP_F   = 4'd8,
        EV_U1_CAP_H   = 4'd9
    } evt_id_e;

    typedef struct packed {
        logic [NUM_EVT-1:0] en;
        logic [NUM_EVT-1:0] pend;
    } flag_set_t;

    // register bit position of the pending flag of event n
    function automatic int pend_pos(int n);
        return (n >= 2) ? n + 14 : n;
    endfunction

    // register bit position of the enable flag of event n
    function automatic int en_pos(int n);
        return (n >= 2) ? n + 22 : n + 8;
    endfunction

    // interrupt line that event n drives
    function automatic int line_of(int n);
        if (n == int'(EV_USB_FAULT)) return 0;
        if (n == int'(EV_USB_DONE))  return 1;
        return ((n - 2) % 2 == 0) ? 1 : 2;
    endfunction

    function automatic logic [NUM_EVT-1:0] group_mask(int line);
        logic [NUM_EVT-1:0] m;
        m = '0;
        for (int n = 0; n < NUM_EVT; n++)
            if (line_of(n) == line) m[n] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] used_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int n = 0; n < NUM_EVT; n++) begin
            m[pend_pos(n)] = 1'b1;
            m[en_pos(n)]   = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/brg_flag_cell.sv
module brg_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wr_en_bit,
    input  logic wr_pend_bit,
    input  logic evt,
    output logic en_q,
    output logic pend_q
);

    logic ack;
    assign ack = wr & ~wr_pend_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wr) en_q <= wr_en_bit;
            pend_q <= (pend_q & ~ack) | evt;
        end
    end

    assert_evt_latch_R1: assert property (@(posedge clk) disable iff (rst)
        evt |=> pend_q);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !(wr && !wr_pend_bit)) |=> pend_q);
    assert_ack_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && !wr_pend_bit && !evt) |=> !pend_q);
    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && !wr_pend_bit && evt) |=> pend_q);
    assert_en_load_R5: assert property (@(posedge clk) disable iff (rst)
        wr |=> (en_q == $past(wr_en_bit)));
    assert_en_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(en_q));

endmodule

// File: rtl/brg_flag_bank.sv
module brg_flag_bank
    import brg_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] evt,
    output flag_set_t          flags
);

    for (genvar n = 0; n < NUM_EVT; n++) begin : g_cell
        localparam int PP = pend_pos(n);
        localparam int EP = en_pos(n);
        brg_flag_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .wr          (wr),
            .wr_en_bit   (wdata[EP]),
            .wr_pend_bit (wdata[PP]),
            .evt         (evt[n]),
            .en_q        (flags.en[n]),
            .pend_q      (flags.pend[n])
        );
    end

endmodule

// File: rtl/brg_irq_merge.sv
module brg_irq_merge
    import brg_irq_pkg::*;
#(
    parameter int LINE = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] hit,
    output logic               irq_q
);

    localparam logic [NUM_EVT-1:0] GRP = group_mask(LINE);

    logic any_hit;
    assign any_hit = |(hit & GRP);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= any_hit;
    end

    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(|(hit & GRP)));
    assert_irq_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_q) |-> !$past(|(hit & GRP)));

endmodule

// File: rtl/brg_irq_ctrl.sv
module brg_irq_ctrl
    import brg_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic [NUM_LINE-1:0] irq_out
);

    localparam logic [REG_W-1:0] USED = used_bits();

    flag_set_t          flags;
    logic [NUM_EVT-1:0] hit;

    brg_flag_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .evt   (evt_pulse),
        .flags (flags)
    );

    assign hit = flags.pend & flags.en;

    for (genvar l = 0; l < NUM_LINE; l++) begin : g_line
        brg_irq_merge #(.LINE(l)) u_merge (
            .clk   (clk),
            .rst   (rst),
            .hit   (hit),
            .irq_q (irq_out[l])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int n = 0; n < NUM_EVT; n++) begin
            reg_rdata[pend_pos(n)] = flags.pend[n];
            reg_rdata[en_pos(n)]   = flags.en[n];
        end
    end

    assert_unused_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~USED) == '0);
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (irq_out == '0 && reg_rdata == '0));
    assert_fault_line_R7: assert property (@(posedge clk) disable iff (rst)
        irq_out[0] |-> $past(reg_rdata[1] && reg_rdata[9]));

endmodule

// File: tb/tb_brg_irq_ctrl.sv
`timescale 1ns/1ps
module tb_brg_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  evt_pulse = '0;
    logic [2:0]  irq_out;

    int vectors = 0;
    int errors  = 0;

    logic [9:0] en_m, pd_m;
    logic [2:0] irq_m;

    always #2.5 clk = ~clk;

    brg_irq_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq_out(irq_out)
    );

    function automatic int tb_pend(int n);
        case (n)
            0: return 0;
            1: return 1;
            default: return 16 + (n - 2);
        endcase
    endfunction

    function automatic int tb_en(int n);
        case (n)
            0: return 8;
            1: return 9;
            default: return 24 + (n - 2);
        endcase
    endfunction

    function automatic logic [31:0] exp_reg();
        logic [31:0] r = '0;
        for (int n = 0; n < 10; n++) begin
            r[tb_pend(n)] = pd_m[n];
            r[tb_en(n)]   = en_m[n];
        end
        return r;
    endfunction

    function automatic logic [2:0] exp_irq(logic [9:0] p, logic [9:0] e);
        logic [9:0] h = p & e;
        return {h[3] | h[5] | h[7] | h[9],
                h[0] | h[2] | h[4] | h[6] | h[8],
                h[1]};
    endfunction

    function automatic logic [31:0] all_pend();
        logic [31:0] r = '0;
        for (int n = 0; n < 10; n++) r[tb_pend(n)] = 1'b1;
        return r;
    endfunction

    task automatic cyc(input logic wr, input logic [31:0] d, input logic [9:0] ev);
        @(negedge clk);
        reg_wr = wr; reg_wdata = d; evt_pulse = ev;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
        irq_m = exp_irq(pd_m, en_m);
        if (wr)
            for (int n = 0; n < 10; n++) begin
                en_m[n] = d[tb_en(n)];
                pd_m[n] = pd_m[n] & d[tb_pend(n)];
            end
        pd_m = pd_m | ev;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        en_m = '0; pd_m = '0; irq_m = '0;
    endtask

    task automatic chk_reg(input string tag);
        vectors++;
        if (reg_rdata !== exp_reg()) begin
            errors++;
            $display("FAIL %s reg: actual %h expected %h", tag, reg_rdata, exp_reg());
        end
    endtask

    task automatic chk_irq(input string tag);
        vectors++;
        if (irq_out !== irq_m) begin
            errors++;
            $display("FAIL %s irq: actual %b expected %b", tag, irq_out, irq_m);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk_reg("R11"); chk_irq("R11");
    endtask

    // R1 R6: every event latches with enables off, no line rises
    task automatic t_latch_masked();
        do_reset();
        for (int n = 0; n < 10; n++) begin
            cyc(1'b0, '0, 10'(1) << n);
            chk_reg("R1_R6");
        end
        cyc(1'b0, '0, '0);
        chk_irq("R1");
    endtask

    // R2: ones over pending bits keep them; R3: single zero clears one
    task automatic t_write_rules();
        cyc(1'b1, all_pend(), '0);
        chk_reg("R2");
        cyc(1'b1, all_pend() & ~(32'(1) << tb_pend(4)), '0);
        chk_reg("R3");
        cyc(1'b1, '0, '0);
        chk_reg("R3");
    endtask

    // R7 R8 R9 R10: each event alone on its own line, timing of rise and fall
    task automatic t_groups();
        for (int n = 0; n < 10; n++) begin
            do_reset();
            cyc(1'b1, 32'(1) << tb_en(n), '0);
            cyc(1'b0, '0, 10'(1) << n);
            chk_irq("R10");
            cyc(1'b0, '0, '0);
            chk_irq(n == 1 ? "R7" : (n == 0 || n % 2 == 0) ? "R8" : "R9");
            cyc(1'b1, 32'(1) << tb_en(n), '0);
            chk_reg("R3");
            chk_irq("R10");
            cyc(1'b0, '0, '0);
            chk_irq("R10");
        end
    endtask

    // R5: masking drops the line, keeps pending
    task automatic t_mask();
        do_reset();
        cyc(1'b1, 32'(1) << tb_en(7), '0);
        cyc(1'b0, '0, 10'h080);
        cyc(1'b0, '0, '0);
        chk_irq("R9");
        cyc(1'b1, 32'(1) << tb_pend(7), '0);
        chk_reg("R5");
        cyc(1'b0, '0, '0);
        chk_irq("R5");
    endtask

    // R4: event on same edge as zero acknowledge
    task automatic t_coincide();
        do_reset();
        cyc(1'b1, 32'(1) << tb_en(1), 10'h002);
        cyc(1'b1, 32'(1) << tb_en(1), 10'h002);
        chk_reg("R4");
        cyc(1'b0, '0, '0);
        chk_irq("R4");
    endtask

    // R12: unused bits read zero; R11: reset with flags set
    task automatic t_unused();
        do_reset();
        cyc(1'b1, 32'hFFFF_FFFF, 10'h3FF);
        chk_reg("R12");
        cyc(1'b0, '0, '0);
        chk_irq("R12");
        do_reset();
        chk_reg("R11"); chk_irq("R11");
    endtask

    initial begin
        en_m = '0; pd_m = '0; irq_m = '0;
        t_reset();
        t_latch_masked();
        t_write_rules();
        t_groups();
        t_mask();
        t_coincide();
        t_unused();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule